// File: doc/BRIEF.md
# Comma-Aligned Four-Lane Receive Word Gatherer

This block sits on the receive side of a serial link, after the clock-data recovery and comma detection logic. It takes one 10-bit character per cycle of the character clock and collects four successive characters into one wide word. The word is then sent on at a quarter of the character rate. Each word is split into three parts: a data field holding the low eight bits of every character, a vector holding each character's bit 8 and a vector holding each character's bit 9. All three parts use the same lane order.

While an external link-synchronized input is high, a synchronizing (comma) character moves the four-character boundary so that the comma opens the next word. A per-lane flag vector marks the lane that holds the comma. While the link is not synchronized, the boundary stays wherever it was, and the flags stay zero even when comma characters arrive. The word clock is modelled as a tick that comes once every four character cycles from a free-running phase counter. Each word passes through a fixed pipeline of word stages, so the latency never changes.

The input is a continuous character stream with no handshake, because a receive lane cannot be paused. The output is valid-only: `wg_valid` strobes for one cycle per word, and the output fields then hold still until the next word tick. There is no ready signal, so the consumer cannot apply back-pressure. It must take each word within the four cycles the word is held.

Top module: `rx_word_gather`

## Requirements
- R1: Each word carries four successive characters. `wg_valid` is a single-cycle strobe, never high on two adjacent cycles, and at most one strobe falls in any four consecutive cycles.
- R2: In `wg_data`, the earliest character of a word takes bits [31:24], the next takes [23:16], the next takes [15:8] and the latest takes [7:0]. These bits come from character bits [7:0].
- R3: `wg_bit8` and `wg_bit9` take character bits 8 and 9, with the earliest character in vector bit 3 and the latest in vector bit 0. This is the same lane order as R2.
- R4: Suppose `link_sync` is high and a comma arrives that would not land in lane 0 (the earliest lane). The boundary then moves so that this comma is lane 0 of the next word. The word that was being collected when the comma arrived is dropped, and no strobe is given in its slot.
- R5: While `link_sync` is low, the boundary never changes, and commas have no effect on word contents or strobes.
- R6: A bit of `wg_comma` is 1 exactly when the character in that lane (bit 3 for earliest, bit 0 for latest) came with `rx_comma` and `link_sync` both high. In any strobed word, only bit 3 can be set.
- R7: A synchronized comma that already falls in lane 0 causes no realignment and no dropped word, and its word carries `wg_comma` = 4'b1000.
- R8: The character tick is the cycle in which the character with phase 3 is sampled. A word whose window closes on tick k appears on the outputs, with its strobe, in the cycle after tick k+3 (twelve character cycles later). The outputs hold steady until the next tick.
- R9: Synchronous reset sets the phase counter to `RST_PHASE` and the boundary offset to zero, and clears all output fields and `wg_valid`. After reset, a word is strobed only if its window closes on or after the seventh character sampled.
- R10: If two synchronized commas that each call for realignment arrive in one window, each one realigns in turn. The last one fixes the boundary, and the first complete word after it starts with that comma.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_char | input | 10 | Received character, one per cycle |
| rx_comma | input | 1 | High when `rx_char` is a synchronizing character |
| link_sync | input | 1 | High while the link is synchronized |
| wg_valid | output | 1 | One-cycle strobe marking a new word |
| wg_data | output | 32 | Bits [7:0] of the four characters |
| wg_bit8 | output | 4 | Bit 8 of the four characters |
| wg_bit9 | output | 4 | Bit 9 of the four characters |
| wg_comma | output | 4 | Synchronized comma position flags |

## Verification
Realignment and the word tick can fall in the same cycle. This happens when a synchronized comma arrives as the phase-3 character, which closes the current window. The bench provokes this by placing commas on every phase in turn, both singly and in pairs within one window. A behavioural model, which tracks the boundary as a start residue over a list of every received character, must then see the closing word dropped and the comma open the next strobed word. A comma that falls on lane 0 in that same closing cycle checks the other side: it must produce no drop at all.

// File: rtl/rx_word_gather_pkg.sv
package rx_word_gather_pkg;
  parameter int unsigned CHAR_W = 10;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned B8_POS = 8;
  parameter int unsigned B9_POS = 9;
endpackage

// File: rtl/rxwg_phase_ctl.sv
module rxwg_phase_ctl #(
  parameter int unsigned LANES     = 4,
  parameter int unsigned RST_PHASE = 0,
  localparam int unsigned PW       = $clog2(LANES),
  localparam int unsigned FILL_MAX = 2 * LANES - 2,
  localparam int unsigned FW       = $clog2(2 * LANES - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          comma_in,
  input  logic          sync_in,
  output logic [PW-1:0] offset,
  output logic          tick,
  output logic          word_ok
);
  logic [PW-1:0] ph_q;
  logic [PW-1:0] off_q;
  logic          pend_q;
  logic [FW-1:0] fill_q;
  logic [PW-1:0] lane_now;
  logic          realign;

  // Lane this character occupies under the current boundary.
  assign lane_now = ph_q + off_q;
  assign realign  = sync_in & comma_in & (lane_now != '0);
  assign tick     = (ph_q == PW'(LANES - 1));
  assign offset   = off_q;
  assign word_ok  = (fill_q == FW'(FILL_MAX)) & ~pend_q & ~realign;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PW'(RST_PHASE);
      off_q  <= '0;
      pend_q <= 1'b0;
      fill_q <= '0;
    end else begin
      ph_q <= ph_q + PW'(1);
      if (realign) off_q <= PW'(0) - ph_q;
      pend_q <= tick ? 1'b0 : (pend_q | realign);
      if (fill_q != FW'(FILL_MAX)) fill_q <= fill_q + FW'(1);
    end
  end

  AST_OFF_HELD_UNSYNCED: assert property (@(posedge clk) disable iff (rst)
    !sync_in |=> $stable(off_q)); // R5

  AST_COMMA_LANDS_LEAD: assert property (@(posedge clk) disable iff (rst)
    realign |=> (ph_q + off_q) == PW'(1)); // R4
endmodule

// File: rtl/rxwg_history.sv
module rxwg_history
  import rx_word_gather_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned HD   = 2 * LANES - 2,
  localparam int unsigned WIN  = 2 * LANES - 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [CHAR_W-1:0]           char_in,
  input  logic                        cq_in,
  output logic [WIN-1:0][CHAR_W-1:0]  win_char,
  output logic [WIN-1:0]              win_cq
);
  logic [HD-1:0][CHAR_W-1:0] hist_q;
  logic [HD-1:0]             hcq_q;

  assign win_char[0] = char_in;
  assign win_cq[0]   = cq_in;

  for (genvar k = 1; k < WIN; k++) begin : g_win
    assign win_char[k] = hist_q[k-1];
    assign win_cq[k]   = hcq_q[k-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      hcq_q  <= '0;
    end else begin
      hist_q <= {hist_q[HD-2:0], char_in};
      hcq_q  <= {hcq_q[HD-2:0], cq_in};
    end
  end
endmodule

// File: rtl/rxwg_lane_sel.sv
module rxwg_lane_sel
  import rx_word_gather_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned WIN  = 2 * LANES - 1,
  localparam int unsigned PW   = $clog2(LANES),
  localparam int unsigned IW   = $clog2(WIN)
) (
  input  logic [WIN-1:0][CHAR_W-1:0] win_char,
  input  logic [WIN-1:0]             win_cq,
  input  logic [PW-1:0]              offset,
  output logic [LANES*DATA_W-1:0]    w_data,
  output logic [LANES-1:0]           w_b8,
  output logic [LANES-1:0]           w_b9,
  output logic [LANES-1:0]           w_flag
);
  // Lane L (0 = earliest) picks the character LANES-1-L+offset back.
  for (genvar L = 0; L < LANES; L++) begin : g_lane
    localparam int unsigned SLOT = LANES - 1 - L;
    logic [IW-1:0] idx;
    assign idx = IW'(SLOT) + IW'(offset);
    assign w_data[SLOT*DATA_W +: DATA_W] = win_char[idx][DATA_W-1:0];
    assign w_b8[SLOT]   = win_char[idx][B8_POS];
    assign w_b9[SLOT]   = win_char[idx][B9_POS];
    assign w_flag[SLOT] = win_cq[idx];
  end
endmodule

// File: rtl/rxwg_word_pipe.sv
module rxwg_word_pipe #(
  parameter int unsigned WW  = 44,
  parameter int unsigned LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          in_ok,
  input  logic [WW-1:0] in_word,
  output logic          out_valid,
  output logic [WW-1:0] out_word
);
  logic [LAT-1:0][WW-1:0] stg_q;
  logic [LAT-1:0]         vld_q;
  logic                   ov_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q[0] <= '0;
      vld_q[0] <= 1'b0;
      ov_q     <= 1'b0;
    end else begin
      ov_q <= tick & vld_q[LAT-2];
      if (tick) begin
        stg_q[0] <= in_word;
        vld_q[0] <= in_ok;
      end
    end
  end

  for (genvar i = 1; i < LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_q[i] <= '0;
        vld_q[i] <= 1'b0;
      end else if (tick) begin
        stg_q[i] <= stg_q[i-1];
        vld_q[i] <= vld_q[i-1];
      end
    end
  end

  assign out_valid = ov_q;
  assign out_word  = stg_q[LAT-1];
endmodule

// File: rtl/rx_word_gather.sv
module rx_word_gather
  import rx_word_gather_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter int unsigned LAT_WORDS = 4,
  parameter int unsigned RST_PHASE = 0,
  localparam int unsigned WIN = 2 * LANES - 1,
  localparam int unsigned PW  = $clog2(LANES),
  localparam int unsigned DW  = LANES * DATA_W,
  localparam int unsigned WW  = DW + 3 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_comma,
  input  logic              link_sync,
  output logic              wg_valid,
  output logic [DW-1:0]     wg_data,
  output logic [LANES-1:0]  wg_bit8,
  output logic [LANES-1:0]  wg_bit9,
  output logic [LANES-1:0]  wg_comma
);
  logic [PW-1:0]             offset;
  logic                      tick;
  logic                      word_ok;
  logic [WIN-1:0][CHAR_W-1:0] win_char;
  logic [WIN-1:0]            win_cq;
  logic [DW-1:0]             w_data;
  logic [LANES-1:0]          w_b8, w_b9, w_flag;
  logic [WW-1:0]             out_word;

  rxwg_phase_ctl #(.LANES(LANES), .RST_PHASE(RST_PHASE)) u_ctl (
    .clk(clk), .rst(rst), .comma_in(rx_comma), .sync_in(link_sync),
    .offset(offset), .tick(tick), .word_ok(word_ok)
  );

  rxwg_history #(.LANES(LANES)) u_hist (
    .clk(clk), .rst(rst), .char_in(rx_char), .cq_in(rx_comma & link_sync),
    .win_char(win_char), .win_cq(win_cq)
  );

  rxwg_lane_sel #(.LANES(LANES)) u_sel (
    .win_char(win_char), .win_cq(win_cq), .offset(offset),
    .w_data(w_data), .w_b8(w_b8), .w_b9(w_b9), .w_flag(w_flag)
  );

  rxwg_word_pipe #(.WW(WW), .LAT(LAT_WORDS)) u_pipe (
    .clk(clk), .rst(rst), .tick(tick), .in_ok(word_ok),
    .in_word({w_data, w_b8, w_b9, w_flag}),
    .out_valid(wg_valid), .out_word(out_word)
  );

  assign {wg_data, wg_bit8, wg_bit9, wg_comma} = out_word;

  AST_FLAG_ONLY_LEAD: assert property (@(posedge clk) disable iff (rst)
    wg_valid |-> (wg_comma[LANES-2:0] == '0)); // R6

  AST_STROBE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    wg_valid |=> (!wg_valid && $stable(wg_data))); // R1
endmodule

// File: tb/rx_word_gather_tb_top.sv
module rx_word_gather_tb_top;
  localparam int RST_PH = 0;
  localparam int NMAX   = 4096;

  logic       clk = 1'b0;
  logic       rst;
  logic [9:0] rx_char;
  logic       rx_comma, link_sync;
  logic       wg_valid;
  logic [31:0] wg_data;
  logic [3:0] wg_bit8, wg_bit9, wg_comma;

  always #2.5 clk = ~clk;

  rx_word_gather #(.LANES(4), .LAT_WORDS(4), .RST_PHASE(RST_PH)) dut_i (
    .clk(clk), .rst(rst), .rx_char(rx_char), .rx_comma(rx_comma),
    .link_sync(link_sync), .wg_valid(wg_valid), .wg_data(wg_data),
    .wg_bit8(wg_bit8), .wg_bit9(wg_bit9), .wg_comma(wg_comma)
  );

  int n_chk = 0, n_bad = 0;
  int words_seen = 0, lead_flags = 0;
  string phase_tag = "R1";

  logic [9:0] mch [NMAX];
  bit         mcq [NMAX];
  bit         ev  [NMAX];
  logic [31:0] ed [NMAX];
  logic [3:0] e8 [NMAX], e9 [NMAX], ef [NMAX];
  int n, res;
  bit drop;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s/%s at char %0d: actual %h expected %h", tag, phase_tag, n, act, exp);
    end
  endtask

  function automatic int phase_of(input int idx);
    return (RST_PH + idx) % 4;
  endfunction

  // Behavioural reference: boundary kept as the phase at which words start.
  task automatic model(input logic [9:0] ch, input bit cm, input bit sy);
    int ph, o, idx;
    ph = phase_of(n);
    mch[n] = ch;
    mcq[n] = cm && sy;
    if (cm && sy && (((ph - res + 4) % 4) != 0)) begin
      res = ph;
      drop = 1'b1;
    end
    if (ph == 3) begin
      o = (4 - res) % 4;
      ev[n] = (n >= 6) && !drop;
      drop = 1'b0;
      ed[n] = '0; e8[n] = '0; e9[n] = '0; ef[n] = '0;
      for (int L = 0; L < 4; L++) begin
        idx = n - 3 - o + L;
        if (idx >= 0) begin
          ed[n][(3-L)*8 +: 8] = mch[idx][7:0];
          e8[n][3-L] = mch[idx][8];
          e9[n][3-L] = mch[idx][9];
          ef[n][3-L] = mcq[idx];
        end
      end
    end
    n++;
  endtask

  task automatic check_out();
    int m;
    bit xv;
    m = n - 1 - 12;
    xv = (m >= 0 && phase_of(m) == 3) ? ev[m] : 1'b0;
    chk("R8", {31'b0, wg_valid}, {31'b0, xv});
    if (xv && wg_valid) begin
      words_seen++;
      if (wg_comma == 4'b1000) lead_flags++;
      chk("R2", wg_data, ed[m]);
      chk("R3", {24'b0, wg_bit8, wg_bit9}, {24'b0, e8[m], e9[m]});
      chk("R6", {28'b0, wg_comma}, {28'b0, ef[m]});
    end
  endtask

  task automatic step(input logic [9:0] ch, input bit cm, input bit sy);
    rx_char = ch; rx_comma = cm; link_sync = sy;
    @(posedge clk);
    if (rst) begin
      n = 0; res = 0; drop = 1'b0;
    end else if (n < NMAX) model(ch, cm, sy);
    @(negedge clk);
    if (!rst) check_out();
    else begin
      // R9: outputs cleared during reset
      chk("R9", {27'b0, wg_valid, wg_comma}, 32'b0);
      chk("R9", wg_data, 32'b0);
    end
  endtask

  task automatic plain(input int cnt, input bit sy);
    for (int i = 0; i < cnt; i++) step(10'($urandom_range(0, 1023)), 1'b0, sy);
  endtask

  function automatic int next_lane();
    return (phase_of(n) - res + 4) % 4;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    plain(3, 1'b0);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog expired: actual running expected done");
    finish_run();
  end

  initial begin
    rst = 1'b1; rx_char = '0; rx_comma = 1'b0; link_sync = 1'b0;
    @(negedge clk);
    phase_tag = "R9";
    do_reset();
    plain(20, 1'b0);
    // R5: commas while unsynchronized change nothing
    phase_tag = "R5";
    for (int i = 0; i < 40; i++) step(10'($urandom_range(0, 1023)), (i % 5) == 2, 1'b0);
    plain(4, 1'b1);
    // R4: synchronized commas on every phase
    phase_tag = "R4";
    for (int k = 0; k < 8; k++) begin
      plain(9 + k, 1'b1);
      step(10'h17C, 1'b1, 1'b1);
    end
    plain(20, 1'b1);
    // R7: commas already on lane 0
    phase_tag = "R7";
    for (int k = 0; k < 6; k++) begin
      while (next_lane() != 0) plain(1, 1'b1);
      step(10'h2BC, 1'b1, 1'b1);
      plain(3 + k, 1'b1);
    end
    plain(16, 1'b1);
    // R10: two commas inside one window
    phase_tag = "R10";
    for (int k = 0; k < 6; k++) begin
      plain(7 + k, 1'b1);
      step(10'h0FC, 1'b1, 1'b1);
      plain(k % 2, 1'b1);
      step(10'h3FC, 1'b1, 1'b1);
    end
    plain(20, 1'b1);
    // R5: link drops, commas ignored, boundary held
    phase_tag = "R5";
    for (int i = 0; i < 30; i++) step(10'($urandom_range(0, 1023)), (i % 3) == 1, 1'b0);
    plain(16, 1'b0);
    // R9: reset mid-stream, first words gated
    phase_tag = "R9";
    do_reset();
    for (int i = 0; i < 20; i++) step(10'($urandom_range(0, 1023)), i == 5, 1'b1);
    plain(20, 1'b1);
    phase_tag = "R1";
    chk("R1", {31'b0, words_seen > 20}, 32'd1);
    chk("R7", {31'b0, lead_flags > 5}, 32'd1);
    finish_run();
  end
endmodule